// File: doc/BRIEF.md
# Per-CPU Device Interrupt Router

The router gathers level-style device interrupt requests into one shared raw request vector and sends them to up to four processors. Each processor owns a mask register. A request line reaches a processor only where that processor's mask bit is set. The pending vector of a processor is not stored. It is always derived as the mask ANDed with the raw request vector, so it stays consistent after every mask write and after every device set or clear.

Device logic changes the request vector through a single set/clear port, one line per cycle. Software uses a 64-bit register port with a one-cycle response. Through it, software writes and reads the masks and reads the pending and raw vectors. The register number is the byte offset shifted right by six. For each processor the block drives three outputs:
- a registered interrupt level;
- a one-cycle pulse when any bit becomes newly pending;
- a one-cycle pulse when any pending bit is withdrawn.

Top module: `irq_router`

## Requirements
- R1: After reset all masks and the raw request vector read as zero, every `cpu_irq`, `cpu_post` and `cpu_wdraw` bit is 0, and `rsp_valid` is 0.
- R2: A legal write (size 8) to register number c (c = 0..NUM_CPU-1, byte offset c*64) replaces the mask of CPU c. A legal read there returns it. Masks not addressed keep their value.
- R3: A read of register number 4+c returns mask(c) AND raw. A read of register number 8 returns the raw request vector.
- R4: `cpu_irq[c]` is the OR of mask(c) AND raw. It takes its new value at the same clock edge that updates the mask or request state, and is visible after that edge.
- R5: `dev_valid`=1 with `dev_set`=1 ORs bit `dev_line` into the raw request vector.
- R6: `dev_valid`=1 with `dev_set`=0 on a line whose raw bit is 0 changes nothing. The raw vector reads the same, and no `cpu_wdraw` or `cpu_post` pulse appears.
- R7: `dev_valid`=1 with `dev_set`=0 on a set line clears that bit. For one cycle it raises `cpu_wdraw[c]` for every CPU c where the bit was pending.
- R8: `cpu_post[c]` is 1 for exactly the cycle after an update that makes at least one bit of CPU c's pending vector go from 0 to 1, whether the update came from a mask write or a request set.
- R9: A mask write that drops a bit that was pending raises `cpu_wdraw[c]` for one cycle.
- R10: An access with `acc_size` not equal to 8 gets `rsp_err`=1 and `rsp_rdata`=0 and changes no state. So does a write to any register number other than 0..NUM_CPU-1, and so does a read of an unmapped register number.
- R11: Every access gets `rsp_valid`=1 in the following cycle. Read data reflects the state before that access's clock edge, and write responses carry zero data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_valid | input | 1 | Register access strobe |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | ADDR_W | Byte offset; register number is bits above 6 |
| acc_size | input | 4 | Access size in bytes; only 8 is legal |
| acc_wdata | input | NUM_LINES | Write data |
| rsp_valid | output | 1 | Response strobe, one cycle after the access |
| rsp_err | output | 1 | Access was rejected |
| rsp_rdata | output | NUM_LINES | Read data, zero on writes and errors |
| dev_valid | input | 1 | Device request update strobe |
| dev_set | input | 1 | 1 = assert the line, 0 = withdraw it |
| dev_line | input | LINE_W | Request line number |
| cpu_irq | output | NUM_CPU | Per-CPU interrupt level |
| cpu_post | output | NUM_CPU | Per-CPU newly-pending pulse |
| cpu_wdraw | output | NUM_CPU | Per-CPU withdrawn-pending pulse |

## Verification
The properties assume that `dev_valid`, `dev_set` and `acc_valid` are held low while reset is asserted. They also assume that only one device update arrives per cycle, which the single port enforces. The bench drives every input at the falling edge, keeps each strobe high for exactly one rising edge, and releases reset before the first stimulus. The sweep takes every one of the 64 request lines through set, clear and spurious clear against four distinct mask patterns, so the checks on the request-line rules always see a well-defined previous state.

// File: rtl/irq_router_pkg.sv
// Package: shared constants and types for the per-CPU interrupt router.
// Assumes at most four CPUs, so the register map slots below stay fixed.
package irq_router_pkg;
    localparam int REG_SHIFT = 6;  // register number = byte offset >> 6
    localparam int PEND_BASE = 4;  // first pending register number
    localparam int RAW_REG   = 8;  // raw request register number
    localparam int ACC_BYTES = 8;  // only legal access size

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_MASK,
        SEL_PEND,
        SEL_RAW
    } rd_sel_e;
endpackage

// File: rtl/irq_reg_decode.sv
// Module: decodes a register access into a read select, per-CPU mask write
// enables and an error flag. Assumes NUM_CPU <= PEND_BASE and NUM_CPU >= 2.
module irq_reg_decode
    import irq_router_pkg::*;
#(
    parameter int NUM_CPU = 4,
    parameter int ADDR_W  = 12,
    localparam int RN_W   = ADDR_W - REG_SHIFT,
    localparam int CPU_W  = $clog2(NUM_CPU)
) (
    input  logic               acc_valid,
    input  logic               acc_write,
    input  logic [ADDR_W-1:0]  acc_addr,
    input  logic [3:0]         acc_size,
    output logic               acc_err,
    output logic [NUM_CPU-1:0] mask_we,
    output rd_sel_e            rd_sel,
    output logic [CPU_W-1:0]   rd_idx
);
    logic [RN_W-1:0] rn;
    logic [RN_W-1:0] pend_off;
    logic            is_mask, is_pend, is_raw, size_ok;
    logic            unused_addr_bits;

    assign rn               = acc_addr[ADDR_W-1:REG_SHIFT];
    assign unused_addr_bits = ^acc_addr[REG_SHIFT-1:0];
    assign pend_off         = rn - RN_W'(PEND_BASE);

    // Classify the register number and the access size.
    always_comb begin
        is_mask = rn < RN_W'(NUM_CPU);
        is_pend = (rn >= RN_W'(PEND_BASE)) && (rn < RN_W'(PEND_BASE + NUM_CPU));
        is_raw  = rn == RN_W'(RAW_REG);
        size_ok = acc_size == 4'(ACC_BYTES);
        acc_err = acc_valid && (!size_ok
                  || (acc_write && !is_mask)
                  || (!acc_write && !(is_mask || is_pend || is_raw)));
    end

    // Pick the read source and the CPU index it refers to.
    always_comb begin
        rd_sel = SEL_NONE;
        if (is_mask)      rd_sel = SEL_MASK;
        else if (is_pend) rd_sel = SEL_PEND;
        else if (is_raw)  rd_sel = SEL_RAW;
        rd_idx = is_pend ? pend_off[CPU_W-1:0] : rn[CPU_W-1:0];
    end

    // One mask write enable per CPU, only for legal writes.
    for (genvar c = 0; c < NUM_CPU; c++) begin : g_we
        assign mask_we[c] = acc_valid && acc_write && !acc_err && (rn == RN_W'(c));
    end
endmodule

// File: rtl/irq_req_reg.sv
// Module: shared raw device request vector, updated one line per cycle
// through a set/clear port. Clears of lines that are not set are ignored.
module irq_req_reg #(
    parameter int NUM_LINES = 64,
    localparam int LINE_W   = $clog2(NUM_LINES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 dev_valid,
    input  logic                 dev_set,
    input  logic [LINE_W-1:0]    dev_line,
    output logic [NUM_LINES-1:0] req_q,
    output logic [NUM_LINES-1:0] req_nxt
);
    logic [NUM_LINES-1:0] line_bit;

    assign line_bit = NUM_LINES'(1) << dev_line;

    // Next raw vector: set ORs the bit in, clear of a set bit removes it.
    always_comb begin
        req_nxt = req_q;
        if (dev_valid && dev_set)
            req_nxt = req_q | line_bit;
        else if (dev_valid && ((req_q & line_bit) != '0))
            req_nxt = req_q & ~line_bit;
    end

    // Hold the raw request vector.
    always_ff @(posedge clk) begin
        if (!rst_n) req_q <= '0;
        else        req_q <= req_nxt;
    end

    a_r5_set_lands: assert property (@(posedge clk) disable iff (!rst_n)
        dev_valid && dev_set |=> req_q[$past(dev_line)]);
    a_r6_spurious_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        dev_valid && !dev_set && !req_q[dev_line] |=> $stable(req_q));
    a_r7_clear_removes: assert property (@(posedge clk) disable iff (!rst_n)
        dev_valid && !dev_set |=> !req_q[$past(dev_line)]);
endmodule

// File: rtl/irq_cpu_slice.sv
// Module: one CPU's mask register and its derived interrupt outputs.
// The pending vector is mask AND raw, never stored; outputs are registered.
module irq_cpu_slice #(
    parameter int NUM_LINES = 64
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 mask_we,
    input  logic [NUM_LINES-1:0] wdata,
    input  logic [NUM_LINES-1:0] req_cur,
    input  logic [NUM_LINES-1:0] req_nxt,
    output logic [NUM_LINES-1:0] mask_q,
    output logic                 irq,
    output logic                 post,
    output logic                 wdraw
);
    logic [NUM_LINES-1:0] mask_nxt, pend_cur, pend_nxt;

    assign mask_nxt = mask_we ? wdata : mask_q;
    assign pend_cur = mask_q & req_cur;
    assign pend_nxt = mask_nxt & req_nxt;

    // Mask register plus level and edge outputs from the next pending view.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
            irq    <= 1'b0;
            post   <= 1'b0;
            wdraw  <= 1'b0;
        end else begin
            mask_q <= mask_nxt;
            irq    <= |pend_nxt;
            post   <= |(pend_nxt & ~pend_cur);
            wdraw  <= |(pend_cur & ~pend_nxt);
        end
    end

    a_r2_mask_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !mask_we |=> $stable(mask_q));
    a_r4_irq_level: assert property (@(posedge clk) disable iff (!rst_n)
        irq == |(mask_q & req_cur));
    a_r8_post_implies_irq: assert property (@(posedge clk) disable iff (!rst_n)
        post |-> irq);
endmodule

// File: rtl/irq_router.sv
// Module: top of the per-CPU device interrupt router. Combines the raw
// request register, one slice per CPU, the access decoder and the
// registered response path. Assumes one access and one device update per cycle.
module irq_router
    import irq_router_pkg::*;
#(
    parameter int NUM_CPU   = 4,
    parameter int NUM_LINES = 64,
    parameter int ADDR_W    = 12,
    localparam int LINE_W   = $clog2(NUM_LINES),
    localparam int CPU_W    = $clog2(NUM_CPU)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 acc_valid,
    input  logic                 acc_write,
    input  logic [ADDR_W-1:0]    acc_addr,
    input  logic [3:0]           acc_size,
    input  logic [NUM_LINES-1:0] acc_wdata,
    output logic                 rsp_valid,
    output logic                 rsp_err,
    output logic [NUM_LINES-1:0] rsp_rdata,
    input  logic                 dev_valid,
    input  logic                 dev_set,
    input  logic [LINE_W-1:0]    dev_line,
    output logic [NUM_CPU-1:0]   cpu_irq,
    output logic [NUM_CPU-1:0]   cpu_post,
    output logic [NUM_CPU-1:0]   cpu_wdraw
);
    logic                 acc_err;
    logic [NUM_CPU-1:0]   mask_we;
    rd_sel_e              rd_sel;
    logic [CPU_W-1:0]     rd_idx;
    logic [NUM_LINES-1:0] req_q, req_nxt, rd_data;
    logic [NUM_LINES-1:0] mask_q [NUM_CPU];

    irq_reg_decode #(.NUM_CPU(NUM_CPU), .ADDR_W(ADDR_W)) u_dec (
        .acc_valid(acc_valid), .acc_write(acc_write), .acc_addr(acc_addr),
        .acc_size(acc_size), .acc_err(acc_err), .mask_we(mask_we),
        .rd_sel(rd_sel), .rd_idx(rd_idx)
    );

    irq_req_reg #(.NUM_LINES(NUM_LINES)) u_req (
        .clk(clk), .rst_n(rst_n), .dev_valid(dev_valid), .dev_set(dev_set),
        .dev_line(dev_line), .req_q(req_q), .req_nxt(req_nxt)
    );

    for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
        irq_cpu_slice #(.NUM_LINES(NUM_LINES)) u_slice (
            .clk(clk), .rst_n(rst_n), .mask_we(mask_we[c]), .wdata(acc_wdata),
            .req_cur(req_q), .req_nxt(req_nxt), .mask_q(mask_q[c]),
            .irq(cpu_irq[c]), .post(cpu_post[c]), .wdraw(cpu_wdraw[c])
        );
    end

    // Select read data from the state before this edge.
    always_comb begin
        case (rd_sel)
            SEL_MASK: rd_data = mask_q[rd_idx];
            SEL_PEND: rd_data = mask_q[rd_idx] & req_q;
            SEL_RAW:  rd_data = req_q;
            default:  rd_data = '0;
        endcase
    end

    // Register the access response one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_err   <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= acc_valid;
            rsp_err   <= acc_err;
            rsp_rdata <= (acc_valid && !acc_write && !acc_err) ? rd_data : '0;
        end
    end

    a_r11_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |=> rsp_valid);
    a_r10_err_no_data: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> rsp_rdata == '0);
    a_r10_err_keeps_masks: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid && acc_err |=> $stable(mask_q[0]) && $stable(req_q));
endmodule

// File: tb/irq_router_bench.sv
`timescale 1ns/1ps
module irq_router_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0, acc_write = 1'b0;
    logic [11:0] acc_addr = '0;
    logic [3:0]  acc_size = '0;
    logic [63:0] acc_wdata = '0;
    logic        rsp_valid, rsp_err;
    logic [63:0] rsp_rdata;
    logic        dev_valid = 1'b0, dev_set = 1'b0;
    logic [5:0]  dev_line = '0;
    logic [3:0]  cpu_irq, cpu_post, cpu_wdraw;

    int n_chk = 0;
    int n_fail = 0;
    logic [63:0] m [4];
    logic [63:0] r;
    logic [63:0] pb [4];

    always #10 clk = ~clk;

    irq_router u_irq_router (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_addr(acc_addr), .acc_size(acc_size), .acc_wdata(acc_wdata),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
        .dev_valid(dev_valid), .dev_set(dev_set), .dev_line(dev_line),
        .cpu_irq(cpu_irq), .cpu_post(cpu_post), .cpu_wdraw(cpu_wdraw)
    );

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic snap();
        for (int c = 0; c < 4; c++) pb[c] = m[c] & r;
    endtask

    // Compare level and pulse outputs with the model (R4, R8, R9, R7).
    task automatic verify(input string req);
        for (int c = 0; c < 4; c++) begin
            logic [63:0] pn;
            pn = m[c] & r;
            chk("R4", $sformatf("irq[%0d]", c), 64'(cpu_irq[c]), 64'(|pn));
            chk(req, $sformatf("post[%0d]", c), 64'(cpu_post[c]), 64'(|(pn & ~pb[c])));
            chk(req, $sformatf("wdraw[%0d]", c), 64'(cpu_wdraw[c]), 64'(|(pb[c] & ~pn)));
        end
    endtask

    task automatic acc(input string req, input logic wr, input int regn,
                       input logic [3:0] size, input logic [63:0] wd,
                       input logic exp_err, input logic [63:0] exp_rd);
        snap();
        acc_valid = 1'b1; acc_write = wr; acc_addr = 12'(regn * 64);
        acc_size = size; acc_wdata = wd;
        @(negedge clk);
        acc_valid = 1'b0; acc_write = 1'b0;
        if (wr && !exp_err) m[regn] = wd;
        chk("R11", "rsp_valid", 64'(rsp_valid), 64'd1);
        chk(req, "rsp_err", 64'(rsp_err), 64'(exp_err));
        chk(req, "rsp_rdata", rsp_rdata, exp_rd);
        verify(wr ? "R9" : req);
    endtask

    task automatic dev(input string req, input logic set, input int line);
        snap();
        dev_valid = 1'b1; dev_set = set; dev_line = 6'(line);
        @(negedge clk);
        dev_valid = 1'b0;
        if (set) r = r | (64'd1 << line);
        else     r = r & ~(64'd1 << line);
        verify(req);
    endtask

    task automatic read_all(input string req);
        for (int c = 0; c < 4; c++) begin
            acc(req, 1'b0, 4 + c, 4'd8, '0, 1'b0, m[c] & r);  // R3 pending
        end
        acc(req, 1'b0, 8, 4'd8, '0, 1'b0, r);                 // R3 raw
    endtask

    initial begin
        #(20 * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int c = 0; c < 4; c++) m[c] = '0;
        r = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        chk("R1", "irq", 64'(cpu_irq), 64'd0);
        chk("R1", "post", 64'(cpu_post), 64'd0);
        chk("R1", "wdraw", 64'(cpu_wdraw), 64'd0);
        chk("R1", "rsp_valid", 64'(rsp_valid), 64'd0);
        for (int c = 0; c < 4; c++) acc("R1", 1'b0, c, 4'd8, '0, 1'b0, 64'd0);
        acc("R1", 1'b0, 8, 4'd8, '0, 1'b0, 64'd0);

        // R2: program four distinct masks and read them back
        acc("R2", 1'b1, 0, 4'd8, {64{1'b1}}, 1'b0, 64'd0);
        acc("R2", 1'b1, 1, 4'd8, {32{2'b10}}, 1'b0, 64'd0);
        acc("R2", 1'b1, 2, 4'd8, {32{2'b01}}, 1'b0, 64'd0);
        acc("R2", 1'b1, 3, 4'd8, 64'h0000_0000_FFFF_0001, 1'b0, 64'd0);
        for (int c = 0; c < 4; c++) acc("R2", 1'b0, c, 4'd8, '0, 1'b0, m[c]);

        // R5/R8: set every line; read the pending views regularly
        for (int l = 0; l < 64; l++) begin
            dev("R8", 1'b1, l);
            if (l % 16 == 15) read_all("R3");
        end
        dev("R5", 1'b1, 7);  // re-set an already set line
        read_all("R5");

        // R9: drop and restore masks while requests are pending
        acc("R9", 1'b1, 3, 4'd8, 64'd0, 1'b0, 64'd0);
        acc("R9", 1'b1, 1, 4'd8, 64'h0000_0000_0000_0002, 1'b0, 64'd0);
        acc("R8", 1'b1, 3, 4'd8, 64'h0000_0000_FFFF_0001, 1'b0, 64'd0);
        read_all("R3");

        // R7/R6: clear each line, then clear it again as a spurious event
        for (int l = 0; l < 64; l++) begin
            dev("R7", 1'b0, l);
            dev("R6", 1'b0, l);
            if (l % 16 == 15) acc("R6", 1'b0, 8, 4'd8, '0, 1'b0, r);
        end
        dev("R5", 1'b1, 63);
        dev("R6", 1'b0, 62);
        acc("R6", 1'b0, 8, 4'd8, '0, 1'b0, r);

        // R10: illegal sizes, read-only writes, unmapped registers
        acc("R10", 1'b0, 0, 4'd4, '0, 1'b1, 64'd0);
        acc("R10", 1'b1, 2, 4'd2, 64'hDEAD, 1'b1, 64'd0);
        acc("R10", 1'b1, 5, 4'd8, 64'hFFFF, 1'b1, 64'd0);
        acc("R10", 1'b1, 8, 4'd8, 64'd0, 1'b1, 64'd0);
        acc("R10", 1'b0, 9, 4'd8, '0, 1'b1, 64'd0);
        acc("R10", 1'b1, 12, 4'd8, 64'h1, 1'b1, 64'd0);
        for (int c = 0; c < 4; c++) acc("R10", 1'b0, c, 4'd8, '0, 1'b0, m[c]);
        acc("R10", 1'b0, 8, 4'd8, '0, 1'b0, r);

        // R11: read right after a write returns the written value
        acc("R11", 1'b1, 0, 4'd8, 64'h8000_0000_0000_0000, 1'b0, 64'd0);
        acc("R11", 1'b0, 0, 4'd8, '0, 1'b0, 64'h8000_0000_0000_0000);
        @(negedge clk);
        chk("R11", "rsp_valid idle", 64'(rsp_valid), 64'd0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule